// File: doc/BRIEF.md
# SD Card Clock Generator with Offset Divisor

This block derives the SD card clock from the core clock. Software loads an 11-bit divisor value that encodes the divide ratio minus two. A value of zero divides by two, and the largest value, 0x7FF, divides by 2049. The block produces two outputs: a registered card clock and a one-cycle clock-enable pulse that marks each rising edge of the card clock. Logic in the core clock domain can use that pulse to launch data toward the card.

The block has two operating modes. After reset it runs in identification mode, which uses all 11 bits of the divisor. The block watches the command stream sent to the card. When it sees the command that selects data transfer (index 15), it moves into data mode. Data mode reads only the low three bits of the same divisor, so the ratio runs from 2 to 9. A slow-card input forces the full divisor at all times and also prevents the move into data mode. Once in data mode, the block stays there until reset.

The control inputs have no back-pressure. A divisor write or a command observation is taken in the cycle its strobe is high. Every change to the divisor, the mode or the slow-card input takes effect at the next rising edge of the card clock. A period that is already running always finishes with the ratio it started with, so no shortened pulse can appear.

Top module: `sdcard_clkgen`

## Requirements
- R1: During and after reset the card clock and the enable pulse are low, the divisor is 0 and the mode is identification, so the first card clock periods last 2 core cycles.
- R2: In identification mode the card clock period is (divisor + 2) core cycles, using all 11 divisor bits.
- R3: A write with `div_wr` high loads all 11 bits of `div_wdata`; the maximum value 0x7FF gives a period of 2049 core cycles.
- R4: In data mode with slow-card low the period is (divisor[2:0] + 2) core cycles, and divisor bits 10..3 have no effect.
- R5: A `cmd_valid` strobe with `cmd_index` equal to 15 while slow-card is low moves the block into data mode; any other index leaves the mode unchanged.
- R6: While `slow_card` is high the full 11-bit divisor is used even in data mode, and an index-15 command does not change the mode.
- R7: A divisor or mode change made in the middle of a period does not alter that period; the new ratio starts at the next rising edge of the card clock.
- R8: `sd_clk_en` is high for exactly one core cycle, and it is high in the same cycle that `sd_clk` rises, and in no other cycle.
- R9: Within a period of N core cycles the card clock is high for floor(N/2) cycles and low for the rest.
- R10: Once in data mode, the block stays in data mode until reset, whatever commands or divisor writes follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_wr | input | 1 | Divisor write strobe |
| div_wdata | input | 11 | Divisor value (ratio minus two) |
| slow_card | input | 1 | Forces the full divisor and blocks the change to data mode |
| cmd_valid | input | 1 | Strobe: a command was issued to the card |
| cmd_index | input | 6 | Index of the issued command |
| sd_clk | output | 1 | Card clock |
| sd_clk_en | output | 1 | One-cycle pulse at each card clock rising edge |

## Verification
The assertions check three properties on every cycle. They check that the enable pulse and the rising edge of the card clock always coincide. They check that the active ratio changes only at a rising edge and that the period counter stays below it. They check that data mode is entered only through an index-15 command with slow-card low, that it is never left, and that the ratio in data mode never exceeds 9. Other behaviour can only be shown through the bench's scenarios, which measure periods and high times at the ports. These scenarios cover the exact period for a given divisor and mode, the slow-card override, the ignored upper bits in data mode, and a write made in the middle of a period that leaves that period at its old length.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  typedef enum logic {
    MODE_IDENT = 1'b0,
    MODE_DATA  = 1'b1
  } sd_mode_e;
endpackage

// File: rtl/sdclk_ctrl.sv
module sdclk_ctrl
  import sdclk_pkg::*;
#(
  parameter int DIV_W      = 11,
  parameter int CMD_W      = 6,
  parameter int SWITCH_CMD = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  input  logic             slow_card,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_index,
  output logic [DIV_W-1:0] div_q,
  output sd_mode_e         mode_q
);
  logic switch_hit;
  assign switch_hit = cmd_valid && (cmd_index == CMD_W'(SWITCH_CMD)) && !slow_card;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      mode_q <= MODE_IDENT;
    end else begin
      if (div_wr) div_q <= div_wdata;
      if (switch_hit) mode_q <= MODE_DATA;
    end
  end

  logic in_data;
  assign in_data = (mode_q == MODE_DATA);

  // R10: data mode is held until reset
  a_r10_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    in_data |=> in_data);
  // R5 / R6: entry only through the switch command while slow-card is low
  a_r5_mode_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_data) |-> $past(cmd_valid && (cmd_index == CMD_W'(SWITCH_CMD)) && !slow_card));
  // R3: divisor changes only after a write
  a_r3_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(div_wr) |-> $stable(div_q));
endmodule

// File: rtl/sdclk_ratio.sv
module sdclk_ratio
  import sdclk_pkg::*;
#(
  parameter int DIV_W   = 11,
  parameter int DATA_W  = 3,
  parameter int RATIO_W = DIV_W + 1
) (
  input  logic [DIV_W-1:0]   div_q,
  input  sd_mode_e           mode_q,
  input  logic               slow_card,
  output logic [RATIO_W-1:0] ratio
);
  logic [RATIO_W-1:0] full_ratio;
  logic [RATIO_W-1:0] narrow_ratio;

  assign full_ratio = {{(RATIO_W-DIV_W){1'b0}}, div_q} + RATIO_W'(2);

  generate
    if (DATA_W >= DIV_W) begin : g_no_narrow
      assign narrow_ratio = full_ratio;
    end else begin : g_narrow
      assign narrow_ratio = {{(RATIO_W-DATA_W){1'b0}}, div_q[DATA_W-1:0]} + RATIO_W'(2);
    end
  endgenerate

  always_comb begin
    if (mode_q == MODE_DATA && !slow_card) ratio = narrow_ratio;
    else                                   ratio = full_ratio;
  end
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen #(
  parameter int RATIO_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio_in,
  output logic               sd_clk,
  output logic               sd_clk_en
);
  logic [RATIO_W-1:0] ratio_q;
  logic [RATIO_W-1:0] cnt;
  logic [RATIO_W-1:0] half;
  logic               wrap;

  assign half = ratio_q >> 1;
  assign wrap = (cnt == ratio_q - RATIO_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ratio_q   <= RATIO_W'(2);
      cnt       <= '0;
      sd_clk    <= 1'b0;
      sd_clk_en <= 1'b0;
    end else begin
      sd_clk_en <= 1'b0;
      if (wrap) begin
        cnt       <= '0;
        sd_clk    <= 1'b1;
        sd_clk_en <= 1'b1;
        ratio_q   <= ratio_in;
      end else begin
        cnt <= cnt + RATIO_W'(1);
        if (cnt == half - RATIO_W'(1)) sd_clk <= 1'b0;
      end
    end
  end

  // R8: enable pulse and rising edge coincide
  a_r8_en_marks_rise: assert property (@(posedge clk) disable iff (!rst_n)
    sd_clk_en |-> (sd_clk && !$past(sd_clk)));
  a_r8_rise_has_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_clk) |-> sd_clk_en);
  // R7: active ratio moves only at a rising edge
  a_r7_ratio_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_clk_en |-> $stable(ratio_q));
  // R2: counter stays inside the active period
  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < ratio_q);
  // R9: falling edge at the middle of the period
  a_r9_fall_mid: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sd_clk) |-> (cnt == half));
endmodule

// File: rtl/sdcard_clkgen.sv
module sdcard_clkgen
  import sdclk_pkg::*;
#(
  parameter int DIV_W         = 11,
  parameter int DATA_DIV_W    = 3,
  parameter int CMD_W         = 6,
  parameter int DATA_MODE_CMD = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  input  logic             slow_card,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_index,
  output logic             sd_clk,
  output logic             sd_clk_en
);
  localparam int RATIO_W   = DIV_W + 1;
  localparam int DATA_RMAX = (1 << DATA_DIV_W) + 1;

  logic [DIV_W-1:0]   div_q;
  sd_mode_e           mode_q;
  logic [RATIO_W-1:0] ratio_sel;

  sdclk_ctrl #(
    .DIV_W(DIV_W), .CMD_W(CMD_W), .SWITCH_CMD(DATA_MODE_CMD)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_wdata(div_wdata),
    .slow_card(slow_card), .cmd_valid(cmd_valid), .cmd_index(cmd_index),
    .div_q(div_q), .mode_q(mode_q)
  );

  sdclk_ratio #(
    .DIV_W(DIV_W), .DATA_W(DATA_DIV_W), .RATIO_W(RATIO_W)
  ) u_ratio (
    .div_q(div_q), .mode_q(mode_q), .slow_card(slow_card), .ratio(ratio_sel)
  );

  sdclk_gen #(
    .RATIO_W(RATIO_W)
  ) u_gen (
    .clk(clk), .rst_n(rst_n), .ratio_in(ratio_sel),
    .sd_clk(sd_clk), .sd_clk_en(sd_clk_en)
  );

  // R4: data mode without slow-card never selects a ratio above the short range
  a_r4_data_range: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_DATA && !slow_card) |-> (ratio_sel <= RATIO_W'(DATA_RMAX)));
  // R6: slow-card always selects the full divisor
  a_r6_slow_full: assert property (@(posedge clk) disable iff (!rst_n)
    slow_card |-> (ratio_sel == {1'b0, div_q} + RATIO_W'(2)));
endmodule

// File: tb/sim_sdcard_clkgen.sv
module sim_sdcard_clkgen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        div_wr = 1'b0;
  logic [10:0] div_wdata = '0;
  logic        slow_card = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [5:0]  cmd_index = '0;
  logic        sd_clk;
  logic        sd_clk_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit dm_model = 0;

  always #2.5 clk = ~clk;

  sdcard_clkgen u0 (
    .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_wdata(div_wdata),
    .slow_card(slow_card), .cmd_valid(cmd_valid), .cmd_index(cmd_index),
    .sd_clk(sd_clk), .sd_clk_en(sd_clk_en)
  );

  function automatic int exp_ratio(logic [10:0] d, bit dm, bit slow);
    if (dm && !slow) return int'(d[2:0]) + 2;
    return int'(d) + 2;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    dm_model = 0;
    repeat (4) @(negedge clk);
    check(sd_clk == 1'b0 && sd_clk_en == 1'b0, "R1 reset outputs", int'(sd_clk) + int'(sd_clk_en), 0);
    rst_n = 1'b1;
  endtask

  task automatic wait_en();
    do @(negedge clk); while (!sd_clk_en);
  endtask

  task automatic measure(output int period, output int high);
    period = 0;
    high = 1;
    forever begin
      @(negedge clk);
      period++;
      if (sd_clk_en) break;
      if (sd_clk) high++;
    end
  endtask

  task automatic write_div(logic [10:0] v);
    @(negedge clk);
    div_wr = 1'b1;
    div_wdata = v;
    @(negedge clk);
    div_wr = 1'b0;
  endtask

  task automatic send_cmd(logic [5:0] idx);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_index = idx;
    if (idx == 6'd15 && !slow_card) dm_model = 1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic settle_check(int exp, string tag);
    int p, h;
    wait_en();
    wait_en();
    measure(p, h);
    check(p == exp, tag, p, exp);
    check(h == exp / 2, "R9 high phase", h, exp / 2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int p, h;
    logic [10:0] d;
    void'($urandom(32'h5D1C_0C4B));
    do_reset();

    wait_en();
    measure(p, h);
    check(p == 2, "R1 first period", p, 2);
    check(h == 1, "R9 first high", h, 1);

    write_div(11'd5);
    settle_check(7, "R2 ident div 5");
    write_div(11'h0F3);
    settle_check(245, "R2 ident full bits");
    write_div(11'h7FF);
    settle_check(2049, "R3 max divisor");

    // R7: mid-period write keeps current period
    write_div(11'd10);
    wait_en(); wait_en();
    @(negedge clk);
    div_wr = 1'b1; div_wdata = 11'd3;
    p = 1;
    forever begin
      @(negedge clk);
      div_wr = 1'b0;
      p++;
      if (sd_clk_en) break;
    end
    check(p == 12, "R7 period in progress", p, 12);
    measure(p, h);
    check(p == 5, "R7 new ratio next period", p, 5);

    // R5: other indices do not switch
    write_div(11'h0F3);
    send_cmd(6'd14);
    send_cmd(6'd31);
    settle_check(245, "R5 non-switch command");
    send_cmd(6'd15);
    settle_check(5, "R5 switch to data mode");
    write_div(11'h7F9);
    settle_check(3, "R4 upper bits ignored");
    write_div(11'h008);
    settle_check(2, "R4 low bits zero");

    // R6: slow-card override in data mode
    write_div(11'h0F3);
    slow_card = 1'b1;
    settle_check(245, "R6 slow forces full");
    slow_card = 1'b0;
    settle_check(5, "R6 slow released");

    // R10: stays in data mode
    send_cmd(6'd0);
    write_div(11'h06C);
    settle_check(6, "R10 sticky data mode");

    // R6: switch command blocked while slow
    do_reset();
    write_div(11'h0F3);
    slow_card = 1'b1;
    send_cmd(6'd15);
    slow_card = 1'b0;
    settle_check(245, "R6 switch blocked by slow");
    send_cmd(6'd15);
    settle_check(5, "R5 switch after slow");

    // random mix
    do_reset();
    for (int i = 0; i < 40; i++) begin
      d = 11'($urandom & 32'h7F);
      if (($urandom & 32'h3) == 0) send_cmd(6'd15);
      else send_cmd(6'($urandom));
      slow_card = (($urandom & 32'h3) == 0);
      write_div(d);
      settle_check(exp_ratio(d, dm_model, slow_card),
                   dm_model && !slow_card ? "R4 random data" : "R2 random ident");
    end
    slow_card = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule